// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor Core

This block is a small processor that knows one operation. Each instruction names three things: a destination operand address, a source operand address and a jump target. The core reads both operands from its on-chip memory and forms destination minus source as a signed 16-bit word. It writes that difference back over the destination. If the difference is negative, the next instruction is taken from the target. If it is not negative, execution moves to the following instruction.

Program and data share one word-addressed memory. An instruction takes three consecutive words, so the sequential successor of an instruction at address `p` is at `p+3`. While reset is held, a host fills the memory through a load port. The host then releases reset and the core runs from address 0. A taken branch to the all-ones address stops the core. A debug port returns any memory word at any time, so results can be inspected once the core has stopped.

Top module: `minus_branch_cpu`

## Requirements
- R1: While `rst` is high, `halted` is low and each clock edge with `loadEn` high writes `loadData` into the memory word at `loadAddr`. After `rst` falls, execution starts at address 0.
- R2: While `rst` is low, `loadEn` has no effect on memory.
- R3: An instruction at address p uses word p as the destination address, word p+1 as the source address and word p+2 as the target. It stores (destination − source) modulo 2^16 into the destination word. The source word is left unchanged.
- R4: When the stored difference has bit 15 set, the next instruction is at the target. Otherwise it is at p+3, and the target is not used.
- R5: A difference of zero does not branch.
- R6: Subtraction wraps on signed overflow, and the sign bit of the wrapped result alone decides the branch.
- R7: A taken branch to the all-ones address raises `halted`. `halted` then stays high, and memory stays unchanged, until `rst` is asserted again.
- R8: Every instruction takes exactly 7 clock cycles. After reset is released, `halted` is first seen high exactly 7·N rising edges later, where N is the number of instructions executed, counting the halting one.
- R9: `dbgData` shows, combinationally, the memory word addressed by `dbgAddr`.
- R10: A non-taken instruction whose target is the all-ones address does not halt the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also enables loading |
| loadEn | input | 1 | Memory load strobe (honoured only during reset) |
| loadAddr | input | ADDR_W | Memory load word address |
| loadData | input | DATA_W | Memory load data |
| dbgAddr | input | ADDR_W | Debug read address |
| dbgData | output | DATA_W | Debug read data |
| halted | output | 1 | High once the core has stopped |

## Verification
The bench checks two things for each test program: the exact edge on which `halted` rises, and the final contents of memory. The core has no other output. A wrong state sequence, a wrong operand latch or a wrong choice of next instruction therefore shows up in one of three ways: `halted` rises on the wrong edge, `halted` never rises, or a word read through the debug port is wrong. Any of these is visible as soon as the program ends. A control-flow error moves the halt edge by a multiple of seven cycles. A datapath error leaves a wrong destination word. The programs include a skipped trap instruction whose data word must survive, so a branch that is wrongly not taken is caught in the same way.

// File: rtl/sbn_pkg.sv
package sbn_pkg;

  // Address source the controller selects for the single core memory access
  typedef enum logic [2:0] {
    SEL_PC0 = 3'd0,
    SEL_PC1 = 3'd1,
    SEL_PC2 = 3'd2,
    SEL_SRC = 3'd3,
    SEL_DST = 3'd4
  } addr_sel_e;

  // Controller states, one memory access each
  typedef enum logic [2:0] {
    ST_FETCH_A = 3'd0,
    ST_FETCH_B = 3'd1,
    ST_FETCH_T = 3'd2,
    ST_READ_S  = 3'd3,
    ST_READ_D  = 3'd4,
    ST_WRITE   = 3'd5,
    ST_UPDATE  = 3'd6,
    ST_HALT    = 3'd7
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      latchA;
    logic      latchB;
    logic      latchT;
    logic      latchSrc;
    logic      latchDst;
    logic      writeBack;
    logic      updatePc;
    addr_sel_e addrSel;
  } ctrl_t;

endpackage

// File: rtl/sbn_mem.sv
module sbn_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [DATA_W-1:0] rData,
  input  logic [ADDR_W-1:0] dAddr,
  output logic [DATA_W-1:0] dData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wAddr] <= wData;
  end

  assign rData = store[rAddr];
  assign dData = store[dAddr];
endmodule

// File: rtl/sbn_datapath.sv
module sbn_datapath
  import sbn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              negFlag,
  output logic              tgtAtEnd,
  output logic [ADDR_W-1:0] pcValue,
  output logic [ADDR_W-1:0] tgtValue
);
  localparam int SIGN_BIT = DATA_W - 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] END_ADDR = '1;

  logic [ADDR_W-1:0] pc, dstAddr, srcAddr, tgt;
  logic [DATA_W-1:0] srcVal, dstVal, diff;
  logic              negReg;

  assign diff = dstVal - srcVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      dstAddr <= '0;
      srcAddr <= '0;
      tgt     <= '0;
      srcVal  <= '0;
      dstVal  <= '0;
      negReg  <= 1'b0;
    end else begin
      if (ctrl.latchA)    dstAddr <= rdData[ADDR_W-1:0];
      if (ctrl.latchB)    srcAddr <= rdData[ADDR_W-1:0];
      if (ctrl.latchT)    tgt     <= rdData[ADDR_W-1:0];
      if (ctrl.latchSrc)  srcVal  <= rdData;
      if (ctrl.latchDst)  dstVal  <= rdData;
      if (ctrl.writeBack) negReg  <= diff[SIGN_BIT];
      if (ctrl.updatePc)  pc      <= negReg ? tgt : pc + STEP;
    end
  end

  always_comb begin
    unique case (ctrl.addrSel)
      SEL_PC1: memAddr = pc + ADDR_W'(1);
      SEL_PC2: memAddr = pc + ADDR_W'(2);
      SEL_SRC: memAddr = srcAddr;
      SEL_DST: memAddr = dstAddr;
      default: memAddr = pc;
    endcase
  end

  assign wrData   = diff;
  assign negFlag  = negReg;
  assign tgtAtEnd = (tgt == END_ADDR);
  assign pcValue  = pc;
  assign tgtValue = tgt;
endmodule

// File: rtl/sbn_control.sv
module sbn_control
  import sbn_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   negFlag,
  input  logic   tgtAtEnd,
  output ctrl_t  ctrl,
  output state_e stateNow,
  output logic   halted
);
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH_A;
    else     state <= nextState;
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      ST_FETCH_A: begin ctrl.addrSel = SEL_PC0; ctrl.latchA   = 1'b1; nextState = ST_FETCH_B; end
      ST_FETCH_B: begin ctrl.addrSel = SEL_PC1; ctrl.latchB   = 1'b1; nextState = ST_FETCH_T; end
      ST_FETCH_T: begin ctrl.addrSel = SEL_PC2; ctrl.latchT   = 1'b1; nextState = ST_READ_S;  end
      ST_READ_S:  begin ctrl.addrSel = SEL_SRC; ctrl.latchSrc = 1'b1; nextState = ST_READ_D;  end
      ST_READ_D:  begin ctrl.addrSel = SEL_DST; ctrl.latchDst = 1'b1; nextState = ST_WRITE;   end
      ST_WRITE:   begin ctrl.addrSel = SEL_DST; ctrl.writeBack = 1'b1; nextState = ST_UPDATE; end
      ST_UPDATE: begin
        ctrl.updatePc = 1'b1;
        nextState = (negFlag && tgtAtEnd) ? ST_HALT : ST_FETCH_A;
      end
      default: nextState = ST_HALT;
    endcase
  end

  assign stateNow = state;
  assign halted   = (state == ST_HALT);
endmodule

// File: rtl/minus_branch_cpu.sv
module minus_branch_cpu
  import sbn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgData,
  output logic              halted
);
  ctrl_t             ctrl;
  state_e            stateNow;
  logic              negFlag, tgtAtEnd, coreWe, memWe;
  logic [ADDR_W-1:0] coreAddr, wAddr, pcValue, tgtValue;
  logic [DATA_W-1:0] rdData, coreData, wData;

  assign coreWe = ctrl.writeBack & ~rst;
  assign memWe  = rst ? loadEn : coreWe;
  assign wAddr  = rst ? loadAddr : coreAddr;
  assign wData  = rst ? loadData : coreData;

  sbn_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) memory (
    .clk(clk), .we(memWe), .wAddr(wAddr), .wData(wData),
    .rAddr(coreAddr), .rData(rdData), .dAddr(dbgAddr), .dData(dbgData)
  );

  sbn_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) datapath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .rdData(rdData),
    .memAddr(coreAddr), .wrData(coreData), .negFlag(negFlag),
    .tgtAtEnd(tgtAtEnd), .pcValue(pcValue), .tgtValue(tgtValue)
  );

  sbn_control control (
    .clk(clk), .rst(rst), .negFlag(negFlag), .tgtAtEnd(tgtAtEnd),
    .ctrl(ctrl), .stateNow(stateNow), .halted(halted)
  );
endmodule

// File: rtl/sbn_checker.sv
module sbn_checker
  import sbn_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic              coreWe,
  input state_e            stateNow,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] tgt
);
  // R1: leaving reset, the core starts at address 0 and is running
  assert_reset_start_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == '0) && !halted);

  // R4: the program counter only ever steps by three or jumps to the target
  assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> (pc == $past(pc) + ADDR_W'(3)) || (pc == $past(tgt)));

  // R7: once stopped, the core stays stopped until reset
  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R7: no memory write after stopping
  assert_no_write_halted_R7: assert property (@(posedge clk) disable iff (rst)
    halted |-> !coreWe);

  // R8: at most one write-back per instruction, never on adjacent cycles
  assert_single_write_R8: assert property (@(posedge clk) disable iff (rst)
    coreWe |=> !coreWe);

  // R8: stopping only follows the next-instruction step
  assert_halt_entry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(stateNow) == ST_UPDATE);
endmodule

bind minus_branch_cpu sbn_checker #(.ADDR_W(ADDR_W)) checker_inst (
  .clk(clk), .rst(rst), .halted(halted), .coreWe(coreWe),
  .stateNow(stateNow), .pc(pcValue), .tgt(tgtValue)
);

// File: tb/minus_branch_cpu_test.sv
`timescale 1ns/1ps
module minus_branch_cpu_test;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] ENDA = '1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              loadEn = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic [DATA_W-1:0] loadData = '0;
  logic [ADDR_W-1:0] dbgAddr = '0;
  logic [DATA_W-1:0] dbgData;
  logic              halted;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] value;
    string             tag;
  } expect_t;

  expect_t sb[$];
  event    drainReq;
  bit      drainBusy = 1'b0;

  always #5 clk = ~clk;

  minus_branch_cpu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .dbgAddr(dbgAddr), .dbgData(dbgData), .halted(halted)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expectWord(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v, input string tag);
    expect_t e;
    e.addr = a; e.value = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: pops expected words and compares them through the debug port
  initial begin
    forever begin
      @(drainReq);
      while (sb.size() > 0) begin
        expect_t e;
        e = sb.pop_front();
        dbgAddr = e.addr;
        #1;
        check(32'(dbgData), 32'(e.value), e.tag);
      end
      drainBusy = 1'b0;
    end
  end

  task automatic drain();
    drainBusy = 1'b1;
    ->drainReq;
    wait (!drainBusy);
  endtask

  task automatic loadWord(input int a, input logic [DATA_W-1:0] v);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = ADDR_W'(a); loadData = v;
  endtask

  task automatic loadInstr(input int p, input int d, input int s, input int t);
    loadWord(p, DATA_W'(d)); loadWord(p + 1, DATA_W'(s)); loadWord(p + 2, DATA_W'(t));
  endtask

  task automatic enterReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(32'(halted), 32'd0, "R1 halted low in reset");
  endtask

  // release reset and count edges until halted; expect 7 per instruction
  task automatic runProgram(input int nInstr, input string tag);
    int cnt;
    @(negedge clk);
    loadEn = 1'b0;
    rst = 1'b0;
    cnt = 0;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      #1;
      cnt++;
      if (halted) break;
    end
    check(32'(halted), 32'd1, {tag, " R7 halted"});
    check(32'(cnt), 32'(7 * nInstr), {tag, " R8 cycles to halt"});
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // ---- program 1: plain subtract, non-taken branch, halt ----
    enterReset();
    loadInstr(0, 20, 21, 5);       // 10 - 3 = 7, target 5 unused
    loadInstr(3, 22, 23, 1023);    // 0 - 1 = -1 -> halt
    loadWord(20, 16'd10); loadWord(21, 16'd3);
    loadWord(22, 16'd0);  loadWord(23, 16'd1);
    runProgram(2, "P1");
    expectWord(20, 16'd7,    "R3 difference stored");
    expectWord(21, 16'd3,    "R3 source unchanged");
    expectWord(22, 16'hFFFF, "R4 negative result stored");
    expectWord(0,  16'd20,   "R1 R9 loaded word readable");
    drain();
    // R2: load port while running out of reset must not write
    @(negedge clk);
    loadEn = 1'b1; loadAddr = ADDR_W'(20); loadData = 16'hBEEF;
    @(negedge clk);
    @(negedge clk);
    loadEn = 1'b0;
    expectWord(20, 16'd7, "R2 load ignored outside reset");
    drain();
    for (int i = 0; i < 20; i++) @(negedge clk);
    check(32'(halted), 32'd1, "R7 halted holds");
    expectWord(22, 16'hFFFF, "R7 memory frozen after halt");
    drain();

    // ---- program 2: overflow, zero, taken branch over a trap ----
    enterReset();
    loadInstr(0, 30, 31, 40);      // 0x8000 - 1 = 0x7FFF, positive
    loadInstr(3, 32, 33, 40);      // 5 - 5 = 0, no branch
    loadInstr(6, 34, 35, 12);      // 3 - 7 = -4, branch to 12
    loadInstr(9, 36, 37, 1023);    // trap, must be skipped
    loadInstr(12, 38, 39, 1023);   // 0x7FFF - (-1) = 0x8000, halt
    loadWord(30, 16'h8000); loadWord(31, 16'd1);
    loadWord(32, 16'd5);    loadWord(33, 16'd5);
    loadWord(34, 16'd3);    loadWord(35, 16'd7);
    loadWord(36, 16'h1111); loadWord(37, 16'd1);
    loadWord(38, 16'h7FFF); loadWord(39, 16'hFFFF);
    runProgram(4, "P2");
    expectWord(30, 16'h7FFF, "R6 wrap to positive no branch");
    expectWord(32, 16'h0000, "R5 zero result stored");
    expectWord(34, 16'hFFFC, "R4 negative difference");
    expectWord(36, 16'h1111, "R4 skipped instruction untouched");
    expectWord(38, 16'h8000, "R6 wrap to negative branches");
    drain();

    // ---- program 3: self-subtract and a counted loop ----
    enterReset();
    loadInstr(0, 50, 50, int'(ENDA)); // x - x = 0, all-ones target, no halt
    loadInstr(3, 51, 52, int'(ENDA)); // counter -= 1, halt when negative
    loadInstr(6, 53, 52, 3);          // always negative: jump back to 3
    loadWord(50, 16'h1234);
    loadWord(51, 16'd3);
    loadWord(52, 16'd1);
    loadWord(53, 16'd0);
    runProgram(8, "P3 R10");
    expectWord(50, 16'h0000, "R10 zero with end target continues");
    expectWord(51, 16'hFFFF, "R4 loop counter final");
    expectWord(53, 16'hFFFD, "R4 backward jumps taken three times");
    expectWord(52, 16'd1,    "R3 shared source unchanged");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule